// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master Controller

This block is a synchronous master for a small serial EEPROM that holds 64 words of 16 bits. A host gives it an operation (read, write, enable programming, disable programming), a word address, write data and a one-cycle start strobe. The block then runs the complete exchange on chip select, serial clock and serial data lines. For a read it returns the 16-bit word, and for every operation it ends with a one-cycle done pulse.

Each command is a start bit, a two-bit opcode and a six-bit address. These nine bits are padded in front with zero bits so that the frame fills whole bytes, and the device skips those zeros. The clock idles low, and outgoing bits change only while the clock is low. Read data is sampled on the falling clock edge, because the device only drives each data bit after a rising edge. After a write the block releases chip select for one half clock period, then raises it again and polls the device's data-out line. It waits for that line to fall (busy) and then rise again (ready). A cycle counter limits the poll and reports a timeout. The program-enable pin is a registered copy of a host input.

State machine: `ST_IDLE` → (start) `ST_CLK_LO` ⇄ `ST_CLK_HI` (one pair per bit) → (last bit) `ST_FRAME_END`. For a write the path continues `ST_GAP` → `ST_WAIT_BUSY` → `ST_WAIT_READY` → `ST_DONE`; for any other operation it goes straight to `ST_DONE`. A timeout in either wait state jumps to `ST_DONE`, and `ST_DONE` always returns to `ST_IDLE`.

Top module: `ee3w_master`

## Requirements
- R1: While reset is held and just after it, cs_o, sck_o, sdo_o, done_o, busy_o and timeout_o are all 0.
- R2: sck_o is 0 whenever cs_o is 0, and it idles at 0 between operations; every clock half period lasts HALF_DIV system clocks.
- R3: A frame begins with (8 - 9 mod 8) = 7 zero bits, then the start bit 1, so that the start bit is the last bit of the first byte; frames are sent MSB first, 16 bits for commands without data and 32 bits for read and write.
- R4: op_i codes are 0 = read, 1 = write, 2 = enable programming, 3 = disable programming; they go on the wire as opcode 10, 01, 00 with address field 110000, and 00 with address field 000000. Enable sends 0x0130 and disable sends 0x0100, and after disable the device ignores writes.
- R5: A write frame is 0x01, then {01, addr}, then the 16 data bits MSB first (for address 5 and data 0xA5C3 this is 0x0145A5C3).
- R6: sdo_o never changes while sck_o is high; new bits appear on the falling edge or while chip select rises.
- R7: A read sends 0x01, then {10, addr}, then 16 zero bits, samples sdi_i on each of the last 16 falling edges MSB first, and presents the word on rdata_o when done_o pulses.
- R8: After a write frame, chip select goes low, returns high one half period later, waits for sdi_i = 0 and then sdi_i = 1, and then goes low before done_o.
- R9: If ready is not seen within TIMEOUT_CYC cycles of the poll start, chip select drops, done_o pulses and timeout_o rises together with it. timeout_o stays high until the next accepted start.
- R10: busy_o is high from the cycle after an accepted start through the done cycle, and a start strobe while busy_o is high has no effect.
- R11: done_o is a single-cycle pulse per operation, and prog_en_o follows prog_en_i one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 2 | Operation code (R4) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| prog_en_i | input | 1 | Host value for the program-enable pin |
| rdata_o | output | DATA_W | Last word read |
| done_o | output | 1 | Operation finished pulse |
| busy_o | output | 1 | Operation in progress |
| timeout_o | output | 1 | Ready poll expired |
| cs_o | output | 1 | Chip select, active high |
| sck_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data to device |
| sdi_i | input | 1 | Serial data from device |
| prog_en_o | output | 1 | Program-enable pin |

## Verification
The checker checks the cycle-level rules on every cycle: the clock stays low while chip select is low, the line is quiet when the block is idle, the data line holds steady while the clock is high, done lasts one cycle, a timeout only appears together with done, busy only ends through done, and program-enable follows its input one cycle later. Frame contents, leading-zero padding, read sampling order, the busy/ready handshake, the ignored start strobe and the timeout path all depend on what the device returns. Only the bench's scenarios can show these, using a behavioural EEPROM model that decodes the frames it receives.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WREN  = 2'd2,
        OP_WRDIS = 2'd3
    } ee_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_FRAME_END,
        ST_GAP,
        ST_WAIT_BUSY,
        ST_WAIT_READY,
        ST_DONE
    } ee_state_e;

endpackage

// File: rtl/ee3w_half_tick.sv
module ee3w_half_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ee3w_poll_timer.sv
module ee3w_poll_timer #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ee3w_master.sv
module ee3w_master
    import ee3w_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int TIMEOUT_CYC = 500000,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              prog_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              timeout_o,
    output logic              cs_o,
    output logic              sck_o,
    output logic              sdo_o,
    input  logic              sdi_i,
    output logic              prog_en_o
);
    localparam int CMD_BITS = 3 + ADDR_W;
    localparam int CMD_PAD  = (8 - (CMD_BITS % 8)) % 8;
    localparam int CMD_W    = CMD_BITS + CMD_PAD;
    localparam int FRAME_W  = CMD_W + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W);

    ee_state_e state_q, state_d;
    ee_op_e    op_q;

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   bitcnt_q;
    logic [DATA_W-1:0]  rx_q;
    logic               tick, expire;

    // frame assembly for a new request
    logic [FRAME_W-1:0] frame_d;
    logic [CNT_W-1:0]   last_idx_d;
    logic [1:0]         code_d;
    logic [ADDR_W-1:0]  field_d;
    logic [DATA_W-1:0]  payload_d;

    always_comb begin
        payload_d  = '0;
        last_idx_d = CNT_W'(FRAME_W - 1);
        unique case (ee_op_e'(op_i))
            OP_READ: begin
                code_d  = 2'b10;
                field_d = addr_i;
            end
            OP_WRITE: begin
                code_d    = 2'b01;
                field_d   = addr_i;
                payload_d = wdata_i;
            end
            OP_WREN: begin
                code_d     = 2'b00;
                field_d    = {2'b11, {(ADDR_W-2){1'b0}}};
                last_idx_d = CNT_W'(CMD_W - 1);
            end
            OP_WRDIS: begin
                code_d     = 2'b00;
                field_d    = '0;
                last_idx_d = CNT_W'(CMD_W - 1);
            end
        endcase
        frame_d = '0;
        frame_d[CMD_BITS+DATA_W-1:DATA_W] = {1'b1, code_d, field_d};
        frame_d[DATA_W-1:0] = payload_d;
    end

    ee3w_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  ((state_q != ST_IDLE) && (state_q != ST_DONE)),
        .tick_o (tick)
    );

    ee3w_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    ((state_q == ST_WAIT_BUSY) || (state_q == ST_WAIT_READY)),
        .expire_o (expire)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_CLK_LO;
            ST_CLK_LO:     if (tick) state_d = ST_CLK_HI;
            ST_CLK_HI:     if (tick) state_d = (bitcnt_q == '0) ? ST_FRAME_END : ST_CLK_LO;
            ST_FRAME_END:  state_d = (op_q == OP_WRITE) ? ST_GAP : ST_DONE;
            ST_GAP:        if (tick) state_d = ST_WAIT_BUSY;
            ST_WAIT_BUSY:  if (expire) state_d = ST_DONE;
                           else if (!sdi_i) state_d = ST_WAIT_READY;
            ST_WAIT_READY: if (expire || sdi_i) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_READ;
            shreg_q   <= '0;
            bitcnt_q  <= '0;
            rx_q      <= '0;
            rdata_o   <= '0;
            timeout_o <= 1'b0;
            cs_o      <= 1'b0;
            sck_o     <= 1'b0;
            sdo_o     <= 1'b0;
            prog_en_o <= 1'b0;
        end else begin
            prog_en_o <= prog_en_i;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q      <= ee_op_e'(op_i);
                        shreg_q   <= frame_d;
                        bitcnt_q  <= last_idx_d;
                        timeout_o <= 1'b0;
                        cs_o      <= 1'b1;
                        sck_o     <= 1'b0;
                        sdo_o     <= frame_d[FRAME_W-1];
                    end
                end
                ST_CLK_LO: begin
                    if (tick) sck_o <= 1'b1;
                end
                ST_CLK_HI: begin
                    if (tick) begin
                        sck_o <= 1'b0;
                        if (op_q == OP_READ && bitcnt_q < CNT_W'(DATA_W))
                            rx_q <= {rx_q[DATA_W-2:0], sdi_i};
                        if (bitcnt_q != '0) begin
                            shreg_q  <= shreg_q << 1;
                            sdo_o    <= shreg_q[FRAME_W-2];
                            bitcnt_q <= bitcnt_q - 1'b1;
                        end
                    end
                end
                ST_FRAME_END: begin
                    cs_o  <= 1'b0;
                    sdo_o <= 1'b0;
                    if (op_q == OP_READ) rdata_o <= rx_q;
                end
                ST_GAP: begin
                    if (tick) cs_o <= 1'b1;
                end
                ST_WAIT_BUSY: begin
                    if (expire) begin
                        cs_o      <= 1'b0;
                        timeout_o <= 1'b1;
                    end
                end
                ST_WAIT_READY: begin
                    if (expire) begin
                        cs_o      <= 1'b0;
                        timeout_o <= !sdi_i;
                    end else if (sdi_i) begin
                        cs_o <= 1'b0;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    assign done_o = (state_q == ST_DONE);
    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/ee3w_master_chk.sv
module ee3w_master_chk (
    input logic clk,
    input logic rst_n,
    input logic done_o,
    input logic busy_o,
    input logic timeout_o,
    input logic cs_o,
    input logic sck_o,
    input logic sdo_o,
    input logic prog_en_i,
    input logic prog_en_o
);
    a_r2_clock_low_without_select: assert property (
        @(posedge clk) disable iff (!rst_n) !cs_o |-> !sck_o);

    a_r6_data_steady_while_high: assert property (
        @(posedge clk) disable iff (!rst_n) (sck_o && $past(sck_o)) |-> $stable(sdo_o));

    a_r10_idle_lines_quiet: assert property (
        @(posedge clk) disable iff (!rst_n) !busy_o |-> (!cs_o && !sck_o));

    a_r10_busy_ends_by_done: assert property (
        @(posedge clk) disable iff (!rst_n) (busy_o && !done_o) |=> busy_o);

    a_r11_done_single: assert property (
        @(posedge clk) disable iff (!rst_n) done_o |=> !done_o);

    a_r9_timeout_with_done: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(timeout_o) |-> done_o);

    a_r11_prog_en_follows: assert property (
        @(posedge clk) disable iff (!rst_n) 1'b1 |=> (prog_en_o == $past(prog_en_i)));
endmodule

bind ee3w_master ee3w_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_o    (done_o),
    .busy_o    (busy_o),
    .timeout_o (timeout_o),
    .cs_o      (cs_o),
    .sck_o     (sck_o),
    .sdo_o     (sdo_o),
    .prog_en_i (prog_en_i),
    .prog_en_o (prog_en_o)
);

// File: tb/tb_ee3w_master.sv
module tb_ee3w_master;
    localparam int BUSY_CYC = 300;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0;
    logic [1:0]  op_i = 0;
    logic [5:0]  addr_i = 0;
    logic [15:0] wdata_i = 0;
    logic        prog_en_i = 0;
    logic [15:0] rdata_o;
    logic        done_o, busy_o, timeout_o, cs_o, sck_o, sdo_o, prog_en_o;
    logic        sdi_i;

    int checks = 0, errors = 0;
    int done_cnt = 0, r6_viol = 0;
    longint cyc = 0, busy_end = 0;
    logic stuck = 0;

    always #10 clk = ~clk;

    ee3w_master #(.HALF_DIV(3), .TIMEOUT_CYC(1500)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .prog_en_i(prog_en_i), .rdata_o(rdata_o), .done_o(done_o),
        .busy_o(busy_o), .timeout_o(timeout_o), .cs_o(cs_o), .sck_o(sck_o),
        .sdo_o(sdo_o), .sdi_i(sdi_i), .prog_en_o(prog_en_o));

    // device model and frame recorder
    logic [15:0] mem [64];
    logic        wen = 0, rd_on = 0, wr_pend = 0, sdi_bit = 0;
    logic [5:0]  raddr = 0;
    logic [31:0] rec = 0;
    int          cnt = 0, fn = 0;
    logic [31:0] fr [16];
    int          fc [16];

    assign sdi_i = rd_on ? sdi_bit : (((cyc < busy_end) || stuck) ? 1'b0 : 1'b1);

    always @(posedge sck_o or negedge cs_o) begin
        if (!cs_o) begin
            fr[fn % 16] = rec;
            fc[fn % 16] = cnt;
            fn++;
            rec = 0; cnt = 0; rd_on = 0;
            if (wr_pend) begin busy_end = cyc + BUSY_CYC; wr_pend = 0; end
        end else begin
            if (rd_on && cnt >= 16) sdi_bit = mem[raddr][31 - cnt];
            rec = {rec[30:0], sdo_o};
            cnt++;
            if (cnt == 16 && rec[8]) begin
                if (rec[7:6] == 2'b10) begin rd_on = 1; raddr = rec[5:0]; end
                if (rec[7:6] == 2'b00 && rec[5:4] == 2'b11) wen = 1;
                if (rec[7:6] == 2'b00 && rec[5:4] == 2'b00) wen = 0;
            end
            if (cnt == 32 && rec[23:22] == 2'b01) begin
                if (wen) mem[rec[21:16]] = rec[15:0];
                wr_pend = 1;
            end
        end
    end

    logic prev_sck = 0, prev_sdo = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done_o) done_cnt <= done_cnt + 1;
        if (rst_n && sck_o && prev_sck && sdo_o != prev_sdo) r6_viol <= r6_viol + 1;
        prev_sck <= sck_o;
        prev_sdo <= sdo_o;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        op_i = op; addr_i = a; wdata_i = d; start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk({cs_o, sck_o, sdo_o, done_o, busy_o, timeout_o} == 6'b0, "R1 reset outputs",
            {cs_o, sck_o, sdo_o, done_o, busy_o, timeout_o}, 0);
    endtask

    task automatic t_prog_en();
        @(negedge clk); prog_en_i = 1;
        @(negedge clk);
        chk(prog_en_o == 1, "R11 prog_en follows", prog_en_o, 1);
        prog_en_i = 0;
        @(negedge clk);
        chk(prog_en_o == 0, "R11 prog_en low", prog_en_o, 0);
    endtask

    task automatic t_cmd(input logic [1:0] op, input logic [15:0] exp, input string tag);
        int b = fn, d = done_cnt;
        pulse_start(op, 6'h2A, 16'hFFFF);
        wait_done();
        chk(fc[b % 16] == 16, {tag, " R3 length"}, fc[b % 16], 16);
        chk(fr[b % 16][15:0] == exp, {tag, " R4 bits"}, fr[b % 16][15:0], exp);
        chk(done_cnt - d == 1, "R11 one done", done_cnt - d, 1);
    endtask

    task automatic t_write(input logic [5:0] a, input logic [15:0] d, input bit probe);
        int b = fn, dc = done_cnt;
        pulse_start(2'd1, a, d);
        if (probe) begin
            repeat (8) @(negedge clk);
            chk(busy_o == 1, "R10 busy during op", busy_o, 1);
            start_i = 1; op_i = 2'd0; @(negedge clk); start_i = 0;
        end
        wait_done();
        chk(fc[b % 16] == 32 && fr[b % 16] == {8'h01, 2'b01, a, d}, "R5 write frame",
            fr[b % 16], {8'h01, 2'b01, a, d});
        chk(fn - b == 2 && fc[(b + 1) % 16] == 0, "R8 poll frame", fn - b, 2);
        chk(timeout_o == 0, "R8 no timeout", timeout_o, 0);
        if (probe) chk(done_cnt - dc == 1, "R10 start ignored", done_cnt - dc, 1);
    endtask

    task automatic t_read(input logic [5:0] a, input logic [15:0] exp, input string tag);
        int b = fn;
        pulse_start(2'd0, a, 16'hFFFF);
        wait_done();
        chk(rdata_o == exp, {tag, " R7 read data"}, rdata_o, exp);
        chk(fc[b % 16] == 32 && fr[b % 16] == {8'h01, 2'b10, a, 16'h0000}, "R7 read frame",
            fr[b % 16], {8'h01, 2'b10, a, 16'h0000});
    endtask

    task automatic t_timeout();
        int dc = done_cnt;
        stuck = 1;
        pulse_start(2'd1, 6'd7, 16'h1234);
        while (!done_o) @(negedge clk);
        chk(timeout_o == 1, "R9 timeout flagged", timeout_o, 1);
        @(negedge clk);
        chk(cs_o == 0 && timeout_o == 1, "R9 select dropped", cs_o, 0);
        chk(done_cnt - dc == 1, "R9 done once", done_cnt - dc, 1);
        stuck = 0;
        pulse_start(2'd2, 6'd0, 16'd0);
        wait_done();
        chk(timeout_o == 0, "R9 cleared on start", timeout_o, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        mem[9] = 16'h8001;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_prog_en();
        t_cmd(2'd2, 16'h0130, "enable");
        t_write(6'd5, 16'hA5C3, 1);
        t_read(6'd5, 16'hA5C3, "written word");
        t_read(6'd9, 16'h8001, "msb first");
        t_cmd(2'd3, 16'h0100, "disable");
        t_write(6'd5, 16'h1111, 0);
        t_read(6'd5, 16'hA5C3, "R4 write after disable");
        t_timeout();
        repeat (5) @(negedge clk);
        chk(sck_o == 0 && cs_o == 0, "R2 idle clock low", sck_o, 0);
        chk(r6_viol == 0, "R6 data steady while high", r6_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule